// File: doc/BRIEF.md
# 64-bit PCI Memory-Write Burst Target

This block is the target side of a PCI bus for 64-bit memory-write bursts. It watches the bus for an address phase and decodes the command and the 64-bit request. It compares the address with a programmed base register that covers a window of `2**BAR_BITS` bytes. On a match it raises a start strobe for each 32-bit half of the backend. One cycle later it claims the transaction, acknowledging both the bus and the 64-bit width. It then completes one data phase on every clock for as long as the initiator holds IRDY# low.

Each completed data phase enters a fixed shift pipeline of `PIPE_LAT` stages. From the pipeline it goes to the backend memory port with a 32-bit word address, 64 bits of data, eight active-high byte enables and one write strobe per half. The word address starts at the 8-byte-aligned word of the bus address and moves forward by two for each phase. A one-cycle done pulse marks the end of the burst on the backend.

The backend port is a write stream in which each strobe acts as valid. There is no ready signal, so the backend cannot apply back-pressure. It must accept a write on every cycle in which a strobe is high, because the bus side never waits. Configuration space, reads, parity, retry and disconnect, and 32-bit-only initiators lie outside this block.

Top module: `pci64_wr_target`

## Requirements
- R1: A transaction is claimed only when all of the following hold on the address-phase edge: FRAME# falls from an idle bus, REQ64# is low, `cbe_lo` equals 4'b0111, and `ad[31:BAR_BITS]` equals `bar_base[31:BAR_BITS]`. Otherwise DEVSEL#, TRDY# and ACK64# stay high and no backend strobe, start or done appears for that transaction.
- R2: On a claim, `be_start_lo` and `be_start_hi` are high together for exactly the one cycle that follows the address-phase edge, while DEVSEL# is still high.
- R3: DEVSEL#, ACK64# and TRDY# go low together one cycle after the start strobes. TRDY# then stays low, so every clock edge with IRDY# low completes a data phase.
- R4: The phase that completes with FRAME# high is the last one. After that edge DEVSEL#, TRDY# and ACK64# are all high again and the target is idle.
- R5: A data phase that completes on edge n is presented on the backend outputs for exactly one cycle, starting at edge n+PIPE_LAT-1 (PIPE_LAT >= 2, default 3). Phases leave in bus order and none is lost or repeated.
- R6: `be_addr` is a 32-bit word index within the window. The first phase uses `ad[BAR_BITS-1:2]` with bit 0 forced to 0. Each later phase adds 2, wrapping modulo `2**(BAR_BITS-2)`.
- R7: `be_data[31:0]` carries `ad[31:0]` (the even word) and `be_data[63:32]` carries `ad[63:32]` (the odd word) of the phase. `be_ben[i]` is 1 when byte-enable bit i was 0 on the bus, where lanes 3..0 come from `cbe_lo` and lanes 7..4 come from `cbe_hi`.
- R8: `be_wr_lo` is high in a phase's backend cycle when any of `be_ben[3:0]` is set, and `be_wr_hi` is high when any of `be_ben[7:4]` is set. A phase with no lane enabled produces no strobe but still uses its address slot.
- R9: `be_done` is a one-cycle pulse in the cycle right after the backend slot of the last phase. It appears even when that slot carried no strobe.
- R10: During and right after reset, DEVSEL#, TRDY# and ACK64# are high, and all start, write and done strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bar_base | input | 32 | Programmed memory base; bits above BAR_BITS are compared |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| req64_n | input | 1 | REQ64#, active low |
| cbe_lo | input | 4 | C/BE#[3:0]: command in address phase, byte enables 3..0 in data phases |
| cbe_hi | input | 4 | C/BE#[7:4]: byte enables 7..4 in data phases |
| ad | input | 64 | AD[63:0]: address then data |
| devsel_n | output | 1 | DEVSEL#, claim |
| trdy_n | output | 1 | TRDY#, target ready |
| ack64_n | output | 1 | ACK64#, 64-bit acknowledge |
| be_start_lo | output | 1 | Backend start, low half |
| be_start_hi | output | 1 | Backend start, high half |
| be_wr_lo | output | 1 | Backend write strobe, low half |
| be_wr_hi | output | 1 | Backend write strobe, high half |
| be_addr | output | BAR_BITS-2 | Backend 32-bit word address (even) |
| be_data | output | 64 | Backend write data |
| be_ben | output | 8 | Backend byte enables, active high |
| be_done | output | 1 | Burst finished pulse |

## Verification
The start strobes are due in the first cycle after the address-phase edge, and the claim signals one cycle after that. A backend write is due PIPE_LAT-1 edges after the edge that completed its phase, and the done pulse one edge after the last write slot. The bench counts clock edges. The bus driver records the edge on which each phase completed and queues the expected write against its due edge. A monitor samples at the falling clock edge and compares each slot exactly on that edge, so an early, late, missing or extra strobe fails.

// File: rtl/pci64_pkg.sv
package pci64_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_SKIP  = 2'd3
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;
  localparam int unsigned BUS_BYTES = 8;
  localparam int unsigned HALF_BYTES = 4;
endpackage

// File: rtl/pci64_bar_decode.sv
module pci64_bar_decode #(
  parameter int unsigned BAR_BITS = 12,
  localparam int unsigned AW = BAR_BITS - 2
) (
  input  logic [31:0]   addr,
  input  logic [3:0]    cmd,
  input  logic          req64_n,
  input  logic [31:0]   bar_base,
  output logic          claim,
  output logic [AW-1:0] start_word
);
  import pci64_pkg::*;

  localparam logic [31:0] WIN_MASK = 32'((64'd1 << BAR_BITS) - 64'd1);

  logic base_hit;
  logic cmd_ok;
  logic [31:0] offset;

  // compare only the bits above the window
  assign base_hit = ((addr ^ bar_base) & ~WIN_MASK) == 32'd0;
  assign cmd_ok   = (cmd == CMD_MEM_WRITE) && !req64_n;
  assign claim    = base_hit && cmd_ok;

  assign offset     = addr & WIN_MASK;
  assign start_word = AW'(offset >> 2);
endmodule

// File: rtl/pci64_tgt_ctrl.sv
module pci64_tgt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic claim,
  output logic load,
  output logic start,
  output logic push,
  output logic push_last,
  output logic devsel_n,
  output logic trdy_n,
  output logic ack64_n
);
  import pci64_pkg::*;

  tgt_state_e st_q, st_d;
  logic frame_q;
  logic addr_phase;

  // an address phase is FRAME# falling from an idle bus
  assign addr_phase = (st_q == ST_IDLE) && !frame_n && frame_q;
  assign load       = addr_phase && claim;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (addr_phase) st_d = claim ? ST_START : ST_SKIP;
      ST_START: st_d = ST_DATA;
      ST_DATA:  if (!irdy_n && frame_n) st_d = ST_IDLE;
      ST_SKIP:  if (frame_n && irdy_n) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      frame_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      frame_q <= frame_n;
    end
  end

  assign start     = (st_q == ST_START);
  assign devsel_n  = (st_q != ST_DATA);
  assign trdy_n    = (st_q != ST_DATA);
  assign ack64_n   = (st_q != ST_DATA);
  assign push      = (st_q == ST_DATA) && !irdy_n;
  assign push_last = push && frame_n;
endmodule

// File: rtl/pci64_burst_addr.sv
module pci64_burst_addr #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_word,
  input  logic          step,
  output logic [AW-1:0] word_addr
);
  localparam logic [AW-1:0] STRIDE = AW'(2);

  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= {start_word[AW-1:1], 1'b0};
    end else if (step) begin
      cnt_q <= cnt_q + STRIDE;
    end
  end

  assign word_addr = cnt_q;
endmodule

// File: rtl/pci64_wr_pipe.sv
module pci64_wr_pipe #(
  parameter int unsigned LAT = 3,
  parameter int unsigned AW  = 10,
  localparam int unsigned W  = 1 + AW + 8 + 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_last,
  input  logic [AW-1:0] in_addr,
  input  logic [7:0]    in_ben,
  input  logic [63:0]   in_data,
  output logic          out_vld,
  output logic          out_last,
  output logic [AW-1:0] out_addr,
  output logic [7:0]    out_ben,
  output logic [63:0]   out_data
);
  logic [LAT-1:0] vld_q;
  logic [W-1:0]   stg_q [LAT];
  logic [W-1:0]   in_word;

  assign in_word = {in_last, in_addr, in_ben, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < int'(LAT); s++) stg_q[s] <= '0;
    end else begin
      vld_q[0] <= in_vld;
      stg_q[0] <= in_word;
      for (int s = 1; s < int'(LAT); s++) begin
        vld_q[s] <= vld_q[s-1];
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign out_vld = vld_q[LAT-1];
  assign {out_last, out_addr, out_ben, out_data} = stg_q[LAT-1];
endmodule

// File: rtl/pci64_wr_target.sv
module pci64_wr_target #(
  parameter int unsigned BAR_BITS = 12,
  parameter int unsigned PIPE_LAT = 3,
  localparam int unsigned AW = BAR_BITS - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   bar_base,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic          req64_n,
  input  logic [3:0]    cbe_lo,
  input  logic [3:0]    cbe_hi,
  input  logic [63:0]   ad,
  output logic          devsel_n,
  output logic          trdy_n,
  output logic          ack64_n,
  output logic          be_start_lo,
  output logic          be_start_hi,
  output logic          be_wr_lo,
  output logic          be_wr_hi,
  output logic [AW-1:0] be_addr,
  output logic [63:0]   be_data,
  output logic [7:0]    be_ben,
  output logic          be_done
);
  import pci64_pkg::*;

  logic          claim, load, start, push, push_last;
  logic [AW-1:0] start_word, word_addr;
  logic          out_vld, out_last;
  logic [1:0]    half_wr;
  logic          done_q;
  logic [7:0]    bus_ben;

  pci64_bar_decode #(.BAR_BITS(BAR_BITS)) u_dec (
    .addr(ad[31:0]), .cmd(cbe_lo), .req64_n(req64_n), .bar_base(bar_base),
    .claim(claim), .start_word(start_word)
  );

  pci64_tgt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .claim(claim), .load(load), .start(start), .push(push),
    .push_last(push_last), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .ack64_n(ack64_n)
  );

  pci64_burst_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .start_word(start_word),
    .step(push), .word_addr(word_addr)
  );

  assign bus_ben = ~{cbe_hi, cbe_lo};

  pci64_wr_pipe #(.LAT(PIPE_LAT), .AW(AW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_vld(push), .in_last(push_last),
    .in_addr(word_addr), .in_ben(bus_ben), .in_data(ad),
    .out_vld(out_vld), .out_last(out_last), .out_addr(be_addr),
    .out_ben(be_ben), .out_data(be_data)
  );

  // one strobe per 32-bit half, only when that half has a live lane
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_wr[h] = out_vld && (|be_ben[h*HALF_BYTES +: HALF_BYTES]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= out_vld && out_last;
  end

  assign be_wr_lo    = half_wr[0];
  assign be_wr_hi    = half_wr[1];
  assign be_start_lo = start;
  assign be_start_hi = start;
  assign be_done     = done_q;
endmodule

// File: rtl/pci64_wr_target_chk.sv
module pci64_wr_target_chk #(
  parameter int unsigned AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_n,
  input logic          irdy_n,
  input logic          devsel_n,
  input logic          trdy_n,
  input logic          ack64_n,
  input logic          be_start_lo,
  input logic          be_wr_lo,
  input logic          be_wr_hi,
  input logic [AW-1:0] be_addr,
  input logic          be_done
);
  logic wr_any;
  assign wr_any = be_wr_lo || be_wr_hi;

  AST_START_BEFORE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    be_start_lo |-> devsel_n);  // R2
  AST_CLAIM_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    be_start_lo |=> !devsel_n);  // R3
  AST_TRDY_WITH_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> (!devsel_n && !ack64_n));  // R3
  AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && ack64_n));  // R4
  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |-> !be_addr[0]);  // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && $past(wr_any)) |-> (be_addr == AW'($past(be_addr) + AW'(2))));  // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    be_done |=> !be_done);  // R9
endmodule

bind pci64_wr_target pci64_wr_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .devsel_n(devsel_n), .trdy_n(trdy_n), .ack64_n(ack64_n),
  .be_start_lo(be_start_lo), .be_wr_lo(be_wr_lo), .be_wr_hi(be_wr_hi),
  .be_addr(be_addr), .be_done(be_done)
);

// File: tb/pci64_wr_target_tb_top.sv
module pci64_wr_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BAR_BITS = 12;
  localparam int PIPE_LAT = 3;
  localparam int AW = BAR_BITS - 2;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, req64_n = 1'b1;
  logic [3:0] cbe_lo = 4'hF, cbe_hi = 4'hF;
  logic [63:0] ad = '0;
  logic devsel_n, trdy_n, ack64_n, be_start_lo, be_start_hi;
  logic be_wr_lo, be_wr_hi, be_done;
  logic [AW-1:0] be_addr;
  logic [63:0] be_data;
  logic [7:0] be_ben;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int done_at = -1;
  bit mon_on = 0;

  int          q_slot[$];
  logic [AW-1:0] q_addr[$];
  logic [63:0] q_data[$];
  logic [7:0]  q_ben[$];
  bit          q_last[$];

  pci64_wr_target #(.BAR_BITS(BAR_BITS), .PIPE_LAT(PIPE_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bar_base(BASE), .frame_n(frame_n),
    .irdy_n(irdy_n), .req64_n(req64_n), .cbe_lo(cbe_lo), .cbe_hi(cbe_hi),
    .ad(ad), .devsel_n(devsel_n), .trdy_n(trdy_n), .ack64_n(ack64_n),
    .be_start_lo(be_start_lo), .be_start_hi(be_start_hi),
    .be_wr_lo(be_wr_lo), .be_wr_hi(be_wr_hi), .be_addr(be_addr),
    .be_data(be_data), .be_ben(be_ben), .be_done(be_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (edge %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [7:0] pick_ben();
    case ($urandom % 6)
      0: return 8'h0F;
      1: return 8'hF0;
      2: return 8'h00;
      3: return 8'hFF;
      default: return 8'($urandom);
    endcase
  endfunction

  function automatic logic [AW-1:0] first_word(input logic [31:0] a);
    logic [AW-1:0] w;
    w = AW'(a[BAR_BITS-1:2]);
    w[0] = 1'b0;
    return w;
  endfunction

  // backend scoreboard, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (q_slot.size() > 0 && q_slot[0] == cyc) begin
        chk(be_wr_lo == (|q_ben[0][3:0]), "R8", "low strobe", 64'(be_wr_lo), 64'(|q_ben[0][3:0]));
        chk(be_wr_hi == (|q_ben[0][7:4]), "R8", "high strobe", 64'(be_wr_hi), 64'(|q_ben[0][7:4]));
        if (|q_ben[0]) begin
          chk(be_addr == q_addr[0], "R6", "word address", 64'(be_addr), 64'(q_addr[0]));
          chk(be_data == q_data[0], "R7", "data", be_data, q_data[0]);
          chk(be_ben == q_ben[0], "R7", "byte enables", 64'(be_ben), 64'(q_ben[0]));
        end
        if (q_last[0]) done_at = cyc + 1;
        void'(q_slot.pop_front()); void'(q_addr.pop_front());
        void'(q_data.pop_front()); void'(q_ben.pop_front()); void'(q_last.pop_front());
      end else if (be_wr_lo || be_wr_hi) begin
        chk(1'b0, "R5", "write outside its slot", 64'({be_wr_hi, be_wr_lo}), 64'd0);
      end
      if (be_done || cyc == done_at)
        chk(be_done == (cyc == done_at), "R9", "done pulse", 64'(be_done), 64'(cyc == done_at));
    end
  end

  task automatic drive_phase(input int idx, input int n,
                             output logic [63:0] d, output logic [7:0] b);
    d = {$urandom, $urandom};
    b = pick_ben();
    ad = d;
    cbe_lo = ~b[3:0];
    cbe_hi = ~b[7:4];
    irdy_n = 1'b0;
    frame_n = (idx == n - 1);
    req64_n = (idx == n - 1);
  endtask

  task automatic burst(input logic [31:0] addr, input int n, input logic [3:0] cmd,
                       input bit r64, input bit hit);
    logic [AW-1:0] wa;
    logic [63:0] d;
    logic [7:0] b;
    bit comp, first;
    int idx;
    @(negedge clk);
    frame_n = 1'b0; req64_n = !r64; ad = {32'h0, addr}; cbe_lo = cmd; cbe_hi = 4'h0;
    irdy_n = 1'b1;
    @(negedge clk);
    if (!hit) begin
      chk(!be_start_lo && !be_start_hi && devsel_n, "R1", "no start on reject",
          64'({be_start_hi, be_start_lo, devsel_n}), 64'b001);
      frame_n = 1'b1; req64_n = 1'b1; irdy_n = 1'b0; ad = {$urandom, $urandom};
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(devsel_n && trdy_n && ack64_n, "R1", "no claim on reject",
            64'({devsel_n, trdy_n, ack64_n}), 64'b111);
      end
      irdy_n = 1'b1;
      repeat (PIPE_LAT + 3) @(negedge clk);
      return;
    end
    chk(be_start_lo && be_start_hi && devsel_n, "R2", "start strobes before claim",
        64'({be_start_hi, be_start_lo, devsel_n}), 64'b111);
    wa = first_word(addr);
    idx = 0;
    first = 1;
    drive_phase(idx, n, d, b);
    comp = !trdy_n;
    forever begin
      @(negedge clk);
      if (first) begin
        chk(!devsel_n && !ack64_n && !trdy_n && !be_start_lo, "R3", "claim one cycle after start",
            64'({devsel_n, ack64_n, trdy_n, be_start_lo}), 64'b0000);
        first = 0;
      end
      if (comp) begin
        // completed on edge cyc; slot due PIPE_LAT-1 edges later (R5)
        q_slot.push_back(cyc + PIPE_LAT - 1); q_addr.push_back(wa);
        q_data.push_back(d); q_ben.push_back(b); q_last.push_back(idx == n - 1);
        wa = wa + AW'(2);
        idx++;
        if (idx == n) begin
          frame_n = 1'b1; irdy_n = 1'b1; req64_n = 1'b1; cbe_lo = 4'hF; cbe_hi = 4'hF;
          chk(devsel_n && trdy_n && ack64_n, "R4", "release after last phase",
              64'({devsel_n, trdy_n, ack64_n}), 64'b111);
          break;
        end
        drive_phase(idx, n, d, b);
      end
      comp = !trdy_n;
    end
    repeat (PIPE_LAT + 3) @(negedge clk);
    chk(q_slot.size() == 0, "R5", "all phases delivered", 64'(q_slot.size()), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "WATCHDOG", "run did not finish", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(devsel_n && trdy_n && ack64_n && !be_start_lo && !be_wr_lo && !be_wr_hi && !be_done,
        "R10", "outputs in reset", 64'({devsel_n, trdy_n, ack64_n, be_start_lo, be_wr_lo,
        be_wr_hi, be_done}), 64'b1110000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(devsel_n && trdy_n && ack64_n && !be_done, "R10", "outputs after reset",
        64'({devsel_n, trdy_n, ack64_n, be_done}), 64'b1110);
    mon_on = 1;
    burst(BASE | 32'h040, 4, 4'b0111, 1, 1);       // four-phase burst
    burst(BASE | 32'h104, 8, 4'b0111, 1, 1);       // eight-phase, odd word start (R6)
    burst(BASE | 32'hFF0, 4, 4'b0111, 1, 1);       // wraps the window (R6)
    burst(BASE | 32'h208, 1, 4'b0111, 1, 1);       // single phase
    burst(32'h9000_0040, 4, 4'b0111, 1, 0);        // base miss (R1)
    burst(BASE | 32'h040, 4, 4'b0110, 1, 0);       // other command (R1)
    burst(BASE | 32'h040, 4, 4'b0111, 0, 0);       // no 64-bit request (R1)
    for (int t = 0; t < 40; t++) begin
      logic [31:0] a;
      int n;
      a = BASE | ($urandom & 32'hFFF);
      n = 1 + int'($urandom % 8);
      if ($urandom % 5 == 0) burst(a ^ 32'h0100_0000, n, 4'b0111, 1, 0);
      else burst(a, n, 4'b0111, 1, 1);
    end
    finish_run();
  end
endmodule